// File: doc/BRIEF.md
# Clocked Serial Byte Transceiver

This block is a full-duplex synchronous serial port that moves one byte at a time. Software writes a byte into a single data buffer and sets a run bit. The block then shifts that byte out on a data output, least significant bit first. At the same time it shifts a byte in from a data input. The shift clock is either made inside the block from the system clock or taken from an external pin. When the eighth bit has been taken in, the received byte replaces the buffer contents and a one-cycle interrupt pulse is raised.

One buffer serves both directions. Between bytes, software must therefore read the received byte before it writes the next byte to send. With the internal clock, the block enforces this by parking the shift clock high until both accesses have happened. With an external clock, the block keeps shifting and never waits. There are two ways to end a transfer. Clearing the run bit lets the current byte finish. The abort bit stops the transfer on the next clock edge.

Top module: `sio_xcvr`

## Requirements
- R1: After reset, the status busy bit (address 3, bit 0) reads 0, the buffer (address 0) reads 0, `sclk_o` is 1, `sdo_o` is 0 and `irq_o` is 0.
- R2: With the internal clock, `sclk_o` has a period of 2*(D+1) system clocks, where D is the divisor field at address 2, bits [6:0]. It stays high whenever the port is not busy.
- R3: On each rising shift-clock edge, the bit on the data input is sampled, LSB first. After the eighth rising edge, the received byte is readable at address 0 and `irq_o` is high for exactly one cycle.
- R4: Writing the control register (address 1) with bit 0 (run) = 1 and bit 1 = 0 while idle sets busy. The buffer contents are loaded for sending at the first falling edge, and each transmit bit changes only on a falling edge, LSB first.
- R5: From start until the first falling edge, `sdo_o` keeps the last bit of the previously sent byte.
- R6: With the internal clock, if run is still 1 when a byte completes, `sclk_o` stays high until address 0 has been both read and written. The next byte then starts.
- R7: With control bit 2 = 1 (external clock), shifting follows the synchronised `sclk_i` edges. Busy stays 1 between bytes while run is 1, and the block never waits for software.
- R8: Clearing run while busy lets the current byte complete. The received byte reaches the buffer, `irq_o` pulses, and then busy clears.
- R9: Writing control bit 1 (abort) = 1 clears busy on the next clock edge and parks `sclk_o` high. It raises no interrupt and leaves the buffer unchanged.
- R10: A control write whose bit 2 differs from the current clock source clears the buffer to 0.
- R11: The control register reads back run in bit 0 and clock source in bit 2. The divisor register reads back its 7-bit field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| sclk_i | input | 1 | External shift clock |
| sdi_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Internally generated shift clock |
| sdo_o | output | 1 | Serial data out |
| irq_o | output | 1 | Byte-complete pulse |

## Verification
Several rules are checked on every cycle by the embedded assertions:
- the shift clock stays high while the port is idle;
- transmit data changes only on falling edges;
- the interrupt lasts a single cycle;
- no internal edge occurs while the port waits for software;
- an abort drops busy on the next edge.

Other behaviours only show up in the bench scenarios:
- that the bytes are shifted LSB first with the right values;
- the divisor-dependent clock period;
- the idle output level before the first edge;
- the wait release, which needs both a read and a write of the buffer;
- graceful stop versus abort;
- clearing of the buffer on a change of clock source.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTL_RUN   = 0;
  localparam int CTL_ABORT = 1;
  localparam int CTL_EXT   = 2;
  localparam int STAT_BUSY = 0;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sio_sclk_gen.sv
module sio_sclk_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == '0);
  assign fall_o = tick && sclk_q;
  assign rise_o = tick && !sclk_q;
  assign sclk_o = sclk_q;

  // half period = half_i + 1 system clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q  <= half_i;
      sclk_q <= 1'b1;
    end else if (tick) begin
      cnt_q  <= half_i;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  a_r2_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_o, rise_o}));
  a_r2_stopped_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> sclk_o);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sd_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q;

  assign done_o = rise_i && (cnt_q == LAST);
  assign rx_o   = {sd_i, rx_q[DATA_W-1:1]};
  assign sdo_o  = sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      if (fall_i) begin
        // first falling edge of a byte takes the buffer as it stands
        if (cnt_q == '0) begin
          sdo_q <= tx_i[0];
          tx_q  <= {1'b0, tx_i[DATA_W-1:1]};
        end else begin
          sdo_q <= tx_q[0];
          tx_q  <= {1'b0, tx_q[DATA_W-1:1]};
        end
      end
      if (rise_i) begin
        rx_q  <= rx_o;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  a_r4_sdo_on_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sdo_o));
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] buf_q;
  logic [DIV_W-1:0]  div_q;
  logic run_q, ext_q, busy_q, wait_q, rd_seen_q, wr_seen_q, irq_q;

  logic wr_buf, rd_buf, wr_ctl, wr_div;
  logic abort_req, start_req, mode_chg;
  logic int_run, int_fall, int_rise;
  logic ext_clk, ext_clk_d, ext_sd, ext_fall, ext_rise;
  logic sh_fall, sh_rise, sh_sd, sh_done;
  logic [DATA_W-1:0] sh_rx;

  assign wr_buf    = reg_wr_i && (reg_addr_i == ADDR_DATA);
  assign rd_buf    = reg_rd_i && (reg_addr_i == ADDR_DATA);
  assign wr_ctl    = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign wr_div    = reg_wr_i && (reg_addr_i == ADDR_DIV);
  assign abort_req = wr_ctl && reg_wdata_i[CTL_ABORT];
  assign start_req = wr_ctl && reg_wdata_i[CTL_RUN] && !reg_wdata_i[CTL_ABORT] && !busy_q;
  assign mode_chg  = wr_ctl && (reg_wdata_i[CTL_EXT] != ext_q);

  // internal clock source
  assign int_run = busy_q && !wait_q && !ext_q;

  sio_sclk_gen #(.DIV_W(DIV_W)) u_sclk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (int_run),
    .half_i (div_q),
    .sclk_o (sclk_o),
    .fall_o (int_fall),
    .rise_o (int_rise)
  );

  // external clock source: clock and data share the same synchroniser depth
  sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sclk_i), .q_o (ext_clk)
  );
  sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sd (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sdi_i), .q_o (ext_sd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_clk_d <= 1'b1;
    else         ext_clk_d <= ext_clk;
  end

  assign ext_fall = !ext_clk && ext_clk_d;
  assign ext_rise = ext_clk && !ext_clk_d;

  assign sh_fall = busy_q && (ext_q ? ext_fall : int_fall);
  assign sh_rise = busy_q && (ext_q ? ext_rise : int_rise);
  assign sh_sd   = ext_q ? ext_sd : sdi_i;

  sio_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_req || abort_req),
    .fall_i (sh_fall),
    .rise_i (sh_rise),
    .sd_i   (sh_sd),
    .tx_i   (buf_q),
    .sdo_o  (sdo_o),
    .rx_o   (sh_rx),
    .done_o (sh_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q     <= '0;
      div_q     <= '0;
      run_q     <= 1'b0;
      ext_q     <= 1'b0;
      busy_q    <= 1'b0;
      wait_q    <= 1'b0;
      rd_seen_q <= 1'b0;
      wr_seen_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= sh_done;
      if (wr_div) div_q <= reg_wdata_i[DIV_W-1:0];
      if (wr_ctl) begin
        run_q <= reg_wdata_i[CTL_RUN] && !reg_wdata_i[CTL_ABORT];
        ext_q <= reg_wdata_i[CTL_EXT];
      end

      // shared buffer: mode change, then received byte, then software write
      if (mode_chg)     buf_q <= '0;
      else if (sh_done) buf_q <= sh_rx;
      else if (wr_buf)  buf_q <= reg_wdata_i;

      if (sh_done) begin
        rd_seen_q <= 1'b0;
        wr_seen_q <= 1'b0;
      end else begin
        if (rd_buf) rd_seen_q <= 1'b1;
        if (wr_buf) wr_seen_q <= 1'b1;
      end

      if (abort_req) begin
        busy_q <= 1'b0;
        wait_q <= 1'b0;
      end else begin
        if (start_req) busy_q <= 1'b1;
        else if (sh_done && !run_q) busy_q <= 1'b0;

        if (mode_chg) wait_q <= 1'b0;
        else if (sh_done && run_q && !ext_q) wait_q <= 1'b1;
        else if (wait_q && rd_seen_q && wr_seen_q) wait_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_DATA: reg_rdata_o = buf_q;
      ADDR_CTRL: begin
        reg_rdata_o[CTL_RUN] = run_q;
        reg_rdata_o[CTL_EXT] = ext_q;
      end
      ADDR_DIV:  reg_rdata_o = DATA_W'(div_q);
      default:   reg_rdata_o[STAT_BUSY] = busy_q;
    endcase
  end

  assign irq_o = irq_q;

  a_r2_idle_sclk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> sclk_o);
  a_r3_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r6_no_edge_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q |-> !sh_fall && !sh_rise);
  a_r7_ext_never_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |-> !wait_q);
  a_r9_abort_drops_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_req |=> !busy_q && !irq_o);
endmodule

// File: tb/sio_xcvr_tb.sv
`timescale 1ns/1ps
module sio_xcvr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sclk_tb = 1'b1;
  logic       sdi = 1'b0;
  logic       sclk_o, sdo_o, irq_o;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  sio_xcvr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sclk_i(sclk_tb), .sdi_i(sdi), .sclk_o(sclk_o), .sdo_o(sdo_o), .irq_o(irq_o)
  );

  // slave model: drives sdi after falling edges, captures sdo at rising edges
  logic       ext_sel = 1'b0;
  logic [7:0] slv_byte = '0;
  int         slv_idx = 0;
  logic [7:0] cap = '0;
  logic       line_d = 1'b1;
  int         cyc = 0, last_fall = -1, period = 0, fall_cnt = 0, irq_cnt = 0;

  always @(negedge clk) begin
    logic line;
    line = ext_sel ? sclk_tb : sclk_o;
    cyc <= cyc + 1;
    if (irq_o) irq_cnt <= irq_cnt + 1;
    if (!line && line_d) begin
      sdi <= slv_byte[slv_idx[2:0]];
      slv_idx <= slv_idx + 1;
      fall_cnt <= fall_cnt + 1;
      if (last_fall >= 0) period <= cyc - last_fall;
      last_fall <= cyc;
    end
    if (line && !line_d) cap <= {sdo_o, cap[7:1]};
    line_d <= line;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int g = 0; g < 5000; g++) begin
      reg_read(2'd3, v);
      if (!v[0]) break;
    end
  endtask

  task automatic wait_irq(input int base);
    for (int g = 0; g < 5000; g++) begin
      if (irq_cnt > base) break;
      @(negedge clk);
    end
  endtask

  task automatic ext_byte();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk_tb = 1'b0;
      repeat (6) @(negedge clk);
      sclk_tb = 1'b1;
      repeat (6) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v, tx, rx, txb, rxb, prev_last;
    int base, fc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd3, v); chk("R1 busy", v[0], 0);
    reg_read(2'd0, v); chk("R1 buffer", v, 8'h00);
    chk("R1 sclk_o", sclk_o, 1); chk("R1 sdo_o", sdo_o, 0); chk("R1 irq_o", irq_o, 0);

    // R11 register readback
    reg_write(2'd2, 8'h55); reg_read(2'd2, v); chk("R11 divisor", v, 8'h55);
    reg_write(2'd2, 8'hFF); reg_read(2'd2, v); chk("R11 divisor width", v, 8'h7F);

    // R2 R3 R4 R5 R8: single graceful-stop bytes over divisors and patterns
    prev_last = 1'b0;
    for (int d = 0; d < 3; d++) begin
      int dv;
      dv = (d == 2) ? 4 : d;
      reg_write(2'd2, 8'(dv));
      for (int k = 0; k < 6; k++) begin
        tx = 8'(k * 37 + dv * 11 + 8'h5A) ^ 8'(1 << k);
        rx = 8'(k * 91 + dv * 29 + 8'hC3);
        reg_write(2'd0, tx);
        slv_byte = rx; slv_idx = 0; last_fall = -1;
        base = irq_cnt;
        reg_write(2'd1, 8'h01);
        chk("R5 idle level before first fall", sdo_o, prev_last[0]);
        reg_write(2'd1, 8'h00);
        wait_idle();
        chk("R4 tx byte LSB first", cap, tx);
        chk("R2 sclk period", period, 2 * (dv + 1));
        chk("R8 one irq per byte", irq_cnt - base, 1);
        reg_read(2'd0, v); chk("R3 rx byte in buffer", v, rx);
        chk("R2 sclk idle high", sclk_o, 1);
        prev_last = {7'b0, tx[7]};
      end
    end

    // R6 wait state with internal clock
    reg_write(2'd2, 8'd1);
    tx = 8'hA6; rx = 8'h3D; txb = 8'h71; rxb = 8'hE8;
    reg_write(2'd0, tx);
    slv_byte = rx; slv_idx = 0;
    base = irq_cnt;
    reg_write(2'd1, 8'h01);
    wait_irq(base);
    repeat (4) @(negedge clk);
    chk("R6 first byte sent", cap, tx);
    slv_byte = rxb; slv_idx = 0;
    fc = fall_cnt;
    repeat (40) @(negedge clk);
    chk("R6 held before access", fall_cnt - fc, 0);
    chk("R6 sclk parked high", sclk_o, 1);
    reg_read(2'd0, v); chk("R3 first rx", v, rx);
    repeat (20) @(negedge clk);
    chk("R6 held after read only", fall_cnt - fc, 0);
    reg_write(2'd0, txb);
    reg_write(2'd1, 8'h00);
    wait_idle();
    chk("R6 resumed eight falls", fall_cnt - fc, 8);
    chk("R6 second byte sent", cap, txb);
    reg_read(2'd0, v); chk("R6 second rx", v, rxb);
    chk("R8 irq count", irq_cnt - base, 2);

    // R9 abort mid-byte
    reg_write(2'd2, 8'd4);
    reg_write(2'd0, 8'hC3);
    slv_byte = 8'h00; slv_idx = 0;
    base = irq_cnt;
    reg_write(2'd1, 8'h01);
    repeat (30) @(negedge clk);
    reg_write(2'd1, 8'h02);
    reg_read(2'd3, v); chk("R9 busy cleared", v[0], 0);
    chk("R9 sclk high", sclk_o, 1);
    repeat (200) @(negedge clk);
    chk("R9 no irq", irq_cnt - base, 0);
    reg_read(2'd0, v); chk("R9 buffer unchanged", v, 8'hC3);
    reg_read(2'd1, v); chk("R11 ctrl after abort", v, 8'h00);

    // R10 mode change clears buffer
    reg_write(2'd0, 8'h5A);
    reg_write(2'd1, 8'h04);
    reg_read(2'd0, v); chk("R10 buffer cleared", v, 8'h00);
    reg_read(2'd1, v); chk("R11 ctrl ext", v, 8'h04);

    // R7 external clock, continuous then graceful
    ext_sel = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tx = 8'(k * 53 + 8'h17); rx = 8'(k * 77 + 8'h8E);
      txb = ~tx; rxb = 8'(rx + 8'h35);
      reg_write(2'd0, tx);
      slv_byte = rx; slv_idx = 0;
      base = irq_cnt;
      reg_write(2'd1, 8'h05);
      ext_byte();
      chk("R7 ext tx", cap, tx);
      chk("R7 ext irq", irq_cnt - base, 1);
      reg_read(2'd0, v); chk("R7 ext rx", v, rx);
      reg_read(2'd3, v); chk("R7 busy between bytes", v[0], 1);
      reg_write(2'd0, txb);
      slv_byte = rxb; slv_idx = 0;
      reg_write(2'd1, 8'h04);
      ext_byte();
      reg_read(2'd3, v); chk("R8 ext graceful stop", v[0], 0);
      chk("R7 ext second tx", cap, txb);
      reg_read(2'd0, v); chk("R7 ext second rx", v, rxb);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule